// File: doc/BRIEF.md
# Super I/O Configuration Controller

This block is the configuration front end of a multi-function I/O chip. It occupies a two-byte window on a byte-wide I/O bus: the even address is an index port and the odd address is a data port. Software unlocks the block by writing a fixed key twice in a row to the index port. Once unlocked, index-port writes select a register and data-port accesses read or write that register. A separate key on the index port locks the block again.

There are 48 global registers below pointer 0x30. Pointer values from 0x30 upward reach a bank of registers that belongs to one of ten logical devices. The device is picked by the value held in global register 7. Writes are filtered by device and by register range. Each accepted data write raises a one-cycle change strobe. The strobe carries the device number, the register index and the bits that flipped, so downstream peripheral logic can reconfigure itself. All registers load fixed defaults on reset.

Top module: `sio_cfg_top`

## Requirements
- R1: After reset the block is locked and the global registers hold 0x03=0x03, 0x20=CHIP_ID (default 0x03), 0x21=0x01, 0x24=0x04, 0x26=0xF0 and 0x27=0x03, with all other globals 0x00. Device 0 holds 0x30=0x01, 0x60=0x03, 0x61=0xF0, 0x70=0x06 and 0x74=0x02. Device 4 holds 0x60=0x03, 0x61=0xF8 and 0x70=0x04. Device 5 holds 0x60=0x02, 0x61=0xF8 and 0x70=0x03. Device 6 holds 0x63=0x70. Device 9 holds all zeros.
- R2: While locked, two consecutive index-port writes of 0x55 unlock the block. An index write of any other value resets the partial key. Writes outside the window (address bits [15:1] differing from BASE_ADDR) are not index writes.
- R3: While unlocked, an index-port write of 0xAA locks the block. Any other index value becomes the register pointer, and the index port reads it back.
- R4: While locked, both ports read 0xFF and data-port writes change nothing and raise no strobe.
- R5: Pointer values 0x00–0x2F address the global registers. Pointer values 0x30–0xFF address the bank of the device numbered by global register 7.
- R6: Bank writes are dropped for devices 1, 2, 6, 7 and for device numbers 10 and above. For devices 0–3, bank writes to 0x70–0x7F are also dropped.
- R7: Bank writes to device 9 are accepted only when global register 0x20 holds 0x03.
- R8: Global registers 0x20 and 0x21 are read-only. Writes to them are dropped.
- R9: Each accepted data write raises chg_valid for exactly the cycle after the write edge. In that cycle chg_dev holds global register 7 as it was before the write, chg_idx holds the pointer, and chg_xor holds the old value XOR the new value. The strobe is raised even when that XOR is zero. Dropped writes raise no strobe.
- R10: A data write updates its register at the clock edge where bus_wr is sampled high. Data-port reads follow the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | I/O address; bit 0 selects index (0) or data (1) |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port (combinational) |
| cfg_active | output | 1 | High while configuration mode is entered |
| chg_valid | output | 1 | One-cycle change strobe |
| chg_dev | output | 8 | Device number at the time of the change |
| chg_idx | output | 8 | Register index that changed |
| chg_xor | output | 8 | Old value XOR new value |

## Verification
The assertions assume a single write per cycle and rely on the key values being observed only on the index port inside the window. A lock or unlock is traced back to the index write of the previous cycle, and a strobe is traced back to a data write made while unlocked. The stimulus drives the bus for one cycle per access with an idle cycle between accesses, so each strobe lines up with exactly one write. Global register 0x20 is never written with an accepted value, so the device-9 gate depends only on the CHIP_ID parameter. A second instance with CHIP_ID 2 shares the same bus so the gate is exercised both ways.

// File: rtl/sio_cfg_pkg.sv
// Shared constants and reset-default tables for the configuration controller.
// Assumes byte-wide registers and pointer values that split at 0x30.
package sio_cfg_pkg;
    localparam int          DW         = 8;
    localparam int          NUM_GLOBAL = 48;
    localparam int          GIDX_W     = $clog2(NUM_GLOBAL);
    localparam int          NUM_DEV    = 10;
    localparam int          BANK_LO    = NUM_GLOBAL;
    localparam int          BANK_SZ    = 256 - BANK_LO;
    localparam logic [7:0]  KEY_OPEN   = 8'h55;
    localparam logic [7:0]  KEY_CLOSE  = 8'hAA;
    localparam logic [7:0]  IDX_DEVSEL = 8'h07;
    localparam logic [7:0]  IDX_ID     = 8'h20;
    localparam logic [7:0]  IDX_REV    = 8'h21;
    localparam logic [7:0]  GATED_ID   = 8'h03;

    // Reset value of a global register.
    function automatic logic [7:0] global_default(input int idx, input logic [7:0] chip_id);
        case (idx)
            3:       return 8'h03;
            32:      return chip_id;
            33:      return 8'h01;
            36:      return 8'h04;
            38:      return 8'hF0;
            39:      return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    // Reset value of a device-bank register, keyed by device and pointer.
    function automatic logic [7:0] dev_default(input int dev, input int idx);
        logic [11:0] key;
        key = {dev[3:0], idx[7:0]};
        case (key)
            12'h030: return 8'h01;  12'h060: return 8'h03;  12'h061: return 8'hF0;
            12'h070: return 8'h06;  12'h074: return 8'h02;  12'h0F0: return 8'h0E;
            12'h0F2: return 8'hFF;
            12'h160: return 8'h01;  12'h161: return 8'hF0;  12'h162: return 8'h03;
            12'h163: return 8'hF6;  12'h170: return 8'h0E;  12'h1F0: return 8'h0C;
            12'h260: return 8'h01;  12'h261: return 8'h70;  12'h262: return 8'h03;
            12'h263: return 8'h76;  12'h270: return 8'h0F;
            12'h330: return 8'h01;  12'h360: return 8'h03;  12'h361: return 8'h78;
            12'h370: return 8'h07;  12'h374: return 8'h04;  12'h3F0: return 8'h3C;
            12'h430: return 8'h01;  12'h460: return 8'h03;  12'h461: return 8'hF8;
            12'h470: return 8'h04;  12'h4F0: return 8'h03;
            12'h530: return 8'h01;  12'h560: return 8'h02;  12'h561: return 8'hF8;
            12'h570: return 8'h03;  12'h574: return 8'h04;  12'h5F1: return 8'h02;
            12'h5F2: return 8'h03;
            12'h663: return 8'h70;  12'h6F4: return 8'h03;
            12'h730: return 8'h01;  12'h761: return 8'h60;  12'h770: return 8'h01;
            12'h830: return 8'h01;  12'h861: return 8'hEA;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/sio_key_fsm.sv
// Lock/unlock tracker and register pointer.
// Assumes idx_wr is already qualified by the address window and is one cycle per write.
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [DW-1:0] wdata,
    output logic          open_q,
    output logic [DW-1:0] ptr_q
);
    typedef enum logic [1:0] {ST_SHUT, ST_HALF, ST_OPEN} key_st_t;
    key_st_t st_q;

    // Advance the key state and capture the pointer on index writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_SHUT;
            ptr_q <= '0;
        end else if (idx_wr) begin
            case (st_q)
                ST_SHUT: st_q <= (wdata == KEY_OPEN) ? ST_HALF : ST_SHUT;
                ST_HALF: st_q <= (wdata == KEY_OPEN) ? ST_OPEN : ST_SHUT;
                default: begin
                    if (wdata == KEY_CLOSE) st_q  <= ST_SHUT;
                    else                    ptr_q <= wdata;
                end
            endcase
        end
    end

    assign open_q = (st_q == ST_OPEN);
endmodule

// File: rtl/sio_global_regs.sv
// The 48 global configuration registers with reset defaults.
// Assumes write filtering (read-only IDs) is done by the caller.
module sio_global_regs
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [GIDX_W-1:0] wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic [GIDX_W-1:0] rd_idx,
    output logic [DW-1:0]     rd_data,
    output logic [DW-1:0]     dev_sel,
    output logic [DW-1:0]     id_val
);
    logic [DW-1:0] regs [NUM_GLOBAL];

    // Load defaults on reset, otherwise store accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_GLOBAL; i++) regs[i] <= global_default(i, CHIP_ID);
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_idx) < NUM_GLOBAL) ? regs[rd_idx] : '0;
    assign dev_sel = regs[IDX_DEVSEL[GIDX_W-1:0]];
    assign id_val  = regs[IDX_ID[GIDX_W-1:0]];
endmodule

// File: rtl/sio_dev_bank.sv
// One logical device's register bank covering pointers 0x30..0xFF.
// Assumes wr_off is at or above 0x30 whenever wr_en is high.
module sio_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter int DEV_ID = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_off,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] rd_off,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [BANK_SZ];
    logic [DW-1:0] wr_rel, rd_rel;

    assign wr_rel = wr_off - DW'(BANK_LO);
    assign rd_rel = rd_off - DW'(BANK_LO);

    // Load defaults on reset, otherwise store accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BANK_SZ; i++) mem[i] <= dev_default(DEV_ID, i + BANK_LO);
        end else if (wr_en && int'(wr_rel) < BANK_SZ) begin
            mem[wr_rel] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_rel) < BANK_SZ) ? mem[rd_rel] : '0;
endmodule

// File: rtl/sio_cfg_top.sv
// Configuration controller top: address decode, write filtering,
// banked read mux and change strobe. Assumes at most one bus write per cycle.
module sio_cfg_top
    import sio_cfg_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [15:0] BASE_ADDR = 16'h03F0,
    parameter logic [7:0]  CHIP_ID   = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          cfg_active,
    output logic          chg_valid,
    output logic [DW-1:0] chg_dev,
    output logic [DW-1:0] chg_idx,
    output logic [DW-1:0] chg_xor
);
    localparam logic [AW-1:0] BASE = AW'(BASE_ADDR);

    logic          hit, idx_wr, dat_wr, is_glob, glob_ok, dev_ok;
    logic          glob_we, bank_we;
    logic [DW-1:0] ptr, glob_rd, dev_sel, id_val, bank_sel_rd, reg_rd;
    logic [DW-1:0] bank_rd [NUM_DEV];

    assign hit     = (bus_addr[AW-1:1] == BASE[AW-1:1]);
    assign idx_wr  = bus_wr && hit && !bus_addr[0];
    assign dat_wr  = bus_wr && hit && bus_addr[0] && cfg_active;
    assign is_glob = (int'(ptr) < BANK_LO);

    sio_key_fsm u_key (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(bus_wdata),
        .open_q(cfg_active), .ptr_q(ptr)
    );

    sio_global_regs #(.CHIP_ID(CHIP_ID)) u_glob (
        .clk(clk), .rst_n(rst_n), .wr_en(glob_we), .wr_idx(ptr[GIDX_W-1:0]),
        .wr_data(bus_wdata), .rd_idx(ptr[GIDX_W-1:0]), .rd_data(glob_rd),
        .dev_sel(dev_sel), .id_val(id_val)
    );

    // Decide whether a global write may land.
    always_comb begin
        glob_ok = (ptr != IDX_ID) && (ptr != IDX_REV);
    end

    // Decide whether a bank write may land for the selected device.
    always_comb begin
        dev_ok = (int'(dev_sel) < NUM_DEV);
        if (dev_sel == 8'd1 || dev_sel == 8'd2 || dev_sel == 8'd6 || dev_sel == 8'd7)
            dev_ok = 1'b0;
        if (dev_sel < 8'd4 && ptr[7:4] == 4'h7)
            dev_ok = 1'b0;
        if (dev_sel == 8'd9 && id_val != GATED_ID)
            dev_ok = 1'b0;
    end

    assign glob_we = dat_wr && is_glob && glob_ok;
    assign bank_we = dat_wr && !is_glob && dev_ok;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
        sio_dev_bank #(.DEV_ID(d)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_en(bank_we && (int'(dev_sel) == d)),
            .wr_off(ptr), .wr_data(bus_wdata),
            .rd_off(ptr), .rd_data(bank_rd[d])
        );
    end

    // Pick the selected device's bank output, 0xFF for unpopulated numbers.
    always_comb begin
        bank_sel_rd = 8'hFF;
        for (int d = 0; d < NUM_DEV; d++)
            if (int'(dev_sel) == d) bank_sel_rd = bank_rd[d];
    end

    assign reg_rd = is_glob ? glob_rd : bank_sel_rd;

    // Drive the read bus: locked or outside the window reads all ones.
    always_comb begin
        if (!cfg_active || !hit) bus_rdata = 8'hFF;
        else if (!bus_addr[0])   bus_rdata = ptr;
        else                     bus_rdata = reg_rd;
    end

    // Register the one-cycle change strobe for accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_valid <= 1'b0;
            chg_dev   <= '0;
            chg_idx   <= '0;
            chg_xor   <= '0;
        end else begin
            chg_valid <= glob_we || bank_we;
            if (glob_we || bank_we) begin
                chg_dev <= dev_sel;
                chg_idx <= ptr;
                chg_xor <= reg_rd ^ bus_wdata;
            end
        end
    end
endmodule

// File: rtl/sio_cfg_chk.sv
// Property checker for the configuration controller, bound to every instance.
// Assumes a synchronous active-low reset and single-cycle bus writes.
module sio_cfg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        cfg_active,
    input logic        chg_valid,
    input logic [7:0]  chg_dev,
    input logic [7:0]  chg_idx
);
    logic idx_write;
    assign idx_write = bus_wr && (bus_addr[15:1] == 15'h01F8) && !bus_addr[0];

    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cfg_active) && $past(rst_n)) |-> $past(idx_write && bus_wdata == 8'h55));

    a_r3_close_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cfg_active) && $past(rst_n)) |-> $past(idx_write && bus_wdata == 8'hAA));

    a_r4_locked_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active |-> (bus_rdata == 8'hFF));

    a_r4_strobe_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_valid && $past(rst_n)) |-> $past(cfg_active && bus_wr && bus_addr[0]));

    a_r8_id_never_changes: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> (chg_idx != 8'h20 && chg_idx != 8'h21));

    a_r6_protected_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_valid && chg_idx >= 8'h30) |->
        (chg_dev < 8'd10 && chg_dev != 8'd1 && chg_dev != 8'd2 &&
         chg_dev != 8'd6 && chg_dev != 8'd7 &&
         !(chg_dev < 8'd4 && chg_idx[7:4] == 4'h7)));
endmodule

bind sio_cfg_top sio_cfg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_active(cfg_active),
    .chg_valid(chg_valid), .chg_dev(chg_dev), .chg_idx(chg_idx)
);

// File: tb/sio_cfg_top_bench.sv
module sio_cfg_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata, rdata_alt;
    logic        cfg_active, cfg_alt;
    logic        chg_valid, chg_valid_alt;
    logic [7:0]  chg_dev, chg_idx, chg_xor, dev_alt, idx_alt, xor_alt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct packed { logic [7:0] dev; logic [7:0] idx; logic [7:0] xr; } chg_t;
    chg_t exp_q[$];

    localparam logic [15:0] IDXP = 16'h03F0;
    localparam logic [15:0] DATP = 16'h03F1;

    always #5 clk = ~clk;

    sio_cfg_top u_sio_cfg_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_active(cfg_active),
        .chg_valid(chg_valid), .chg_dev(chg_dev), .chg_idx(chg_idx), .chg_xor(chg_xor)
    );

    sio_cfg_top #(.CHIP_ID(8'h02)) u_sio_cfg_top_alt (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_alt), .cfg_active(cfg_alt),
        .chg_valid(chg_valid_alt), .chg_dev(dev_alt), .chg_idx(idx_alt), .chg_xor(xor_alt)
    );

    // Monitor: every strobe on the main instance must match the next expected item (R9).
    always @(negedge clk) begin
        if (rst_n && chg_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R9 unexpected strobe: actual dev=%h idx=%h xor=%h expected none",
                         chg_dev, chg_idx, chg_xor);
            end else begin
                chg_t e;
                e = exp_q.pop_front();
                if ({chg_dev, chg_idx, chg_xor} !== e) begin
                    bad++;
                    $display("FAIL R9 strobe: actual %h/%h/%h expected %h/%h/%h",
                             chg_dev, chg_idx, chg_xor, e.dev, e.idx, e.xr);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // Driver: data write, pushing the expected strobe when the write should land.
    task automatic put(input logic [7:0] val, input bit acc, input logic [7:0] dev,
                       input logic [7:0] idx, input logic [7:0] old);
        if (acc) exp_q.push_back({dev, idx, old ^ val});
        bus_write(DATP, val);
    endtask

    task automatic check_rd(input bit alt, input logic [15:0] a, input logic [7:0] exp,
                            input string tag);
        logic [7:0] act;
        @(negedge clk);
        bus_addr = a;
        bus_wr   = 1'b0;
        #1;
        act = alt ? rdata_alt : bus_rdata;
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s read %h: actual %h expected %h", tag, a, act, exp);
        end
    endtask

    task automatic check_reg(input logic [7:0] p, input logic [7:0] exp, input string tag);
        bus_write(IDXP, p);
        check_rd(1'b0, DATP, exp, tag);
    endtask

    task automatic check_open(input logic exp, input string tag);
        #1;
        total++;
        if (cfg_active !== exp) begin
            bad++;
            $display("FAIL %s cfg_active: actual %b expected %b", tag, cfg_active, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R4: locked after reset, reads all ones
        check_open(1'b0, "R1");
        check_rd(1'b0, IDXP, 8'hFF, "R4");
        check_rd(1'b0, DATP, 8'hFF, "R4");

        // R4: data write while locked has no effect (global 0 stays 0)
        put(8'h12, 1'b0, 8'h00, 8'h00, 8'h00);

        // R2: key outside window, broken key, then a clean key
        bus_write(16'h02F0, 8'h55);
        bus_write(16'h02F0, 8'h55);
        check_open(1'b0, "R2");
        bus_write(IDXP, 8'h55);
        bus_write(IDXP, 8'h11);
        bus_write(IDXP, 8'h55);
        check_open(1'b0, "R2");
        bus_write(IDXP, 8'h55);
        check_open(1'b1, "R2");

        check_reg(8'h00, 8'h00, "R4");
        // R3: pointer readback
        bus_write(IDXP, 8'h20);
        check_rd(1'b0, IDXP, 8'h20, "R3");
        // R1: global defaults, both chip variants
        check_rd(1'b0, DATP, 8'h03, "R1");
        check_rd(1'b1, DATP, 8'h02, "R1");
        check_reg(8'h03, 8'h03, "R1");
        check_reg(8'h24, 8'h04, "R1");
        check_reg(8'h26, 8'hF0, "R1");
        check_reg(8'h27, 8'h03, "R1");

        // R8: read-only identification registers
        bus_write(IDXP, 8'h21);
        put(8'h55, 1'b0, 8'h00, 8'h21, 8'h01);
        check_rd(1'b0, DATP, 8'h01, "R8");
        bus_write(IDXP, 8'h20);
        put(8'h07, 1'b0, 8'h00, 8'h20, 8'h03);
        check_rd(1'b0, DATP, 8'h03, "R8");

        // R10 / R9: global write lands and strobes
        bus_write(IDXP, 8'h22);
        put(8'h3B, 1'b1, 8'h00, 8'h22, 8'h00);
        check_rd(1'b0, DATP, 8'h3B, "R10");
        // R9: unchanged value still strobes with xor 0
        bus_write(IDXP, 8'h07);
        put(8'h00, 1'b1, 8'h00, 8'h07, 8'h00);

        // R5 / R1: device 0 bank
        check_reg(8'h30, 8'h01, "R1");
        check_reg(8'h60, 8'h03, "R5");
        check_reg(8'h61, 8'hF0, "R5");
        check_reg(8'h74, 8'h02, "R1");
        bus_write(IDXP, 8'h60);
        put(8'h04, 1'b1, 8'h00, 8'h60, 8'h03);
        check_rd(1'b0, DATP, 8'h04, "R10");
        // R6: 0x70 range blocked for device 0
        bus_write(IDXP, 8'h70);
        put(8'h05, 1'b0, 8'h00, 8'h70, 8'h06);
        check_rd(1'b0, DATP, 8'h06, "R6");

        // R5: select device 4
        bus_write(IDXP, 8'h07);
        put(8'h04, 1'b1, 8'h00, 8'h07, 8'h00);
        check_reg(8'h61, 8'hF8, "R5");
        check_reg(8'h70, 8'h04, "R1");
        put(8'h07, 1'b1, 8'h04, 8'h70, 8'h04);
        check_rd(1'b0, DATP, 8'h07, "R6");

        // device 5 defaults
        bus_write(IDXP, 8'h07);
        put(8'h05, 1'b1, 8'h04, 8'h07, 8'h04);
        check_reg(8'h60, 8'h02, "R1");
        check_reg(8'h70, 8'h03, "R1");

        // R6: device 1 fully protected
        bus_write(IDXP, 8'h07);
        put(8'h01, 1'b1, 8'h05, 8'h07, 8'h05);
        bus_write(IDXP, 8'h60);
        put(8'h09, 1'b0, 8'h01, 8'h60, 8'h01);
        check_rd(1'b0, DATP, 8'h01, "R6");

        // R6: device 6 protected
        bus_write(IDXP, 8'h07);
        put(8'h06, 1'b1, 8'h01, 8'h07, 8'h01);
        bus_write(IDXP, 8'h63);
        put(8'h12, 1'b0, 8'h06, 8'h63, 8'h70);
        check_rd(1'b0, DATP, 8'h70, "R6");

        // R7: device 9 gated by chip id
        bus_write(IDXP, 8'h07);
        put(8'h09, 1'b1, 8'h06, 8'h07, 8'h06);
        bus_write(IDXP, 8'h30);
        put(8'h01, 1'b1, 8'h09, 8'h30, 8'h00);
        check_rd(1'b0, DATP, 8'h01, "R7");
        check_rd(1'b1, DATP, 8'h00, "R7");

        // R6: device 3 0x7F blocked
        bus_write(IDXP, 8'h07);
        put(8'h03, 1'b1, 8'h09, 8'h07, 8'h09);
        bus_write(IDXP, 8'h7F);
        put(8'h5A, 1'b0, 8'h03, 8'h7F, 8'h00);
        check_rd(1'b0, DATP, 8'h00, "R6");

        // R6: device number 12 blocked, reads all ones
        bus_write(IDXP, 8'h07);
        put(8'h0C, 1'b1, 8'h03, 8'h07, 8'h03);
        bus_write(IDXP, 8'h40);
        put(8'h33, 1'b0, 8'h0C, 8'h40, 8'hFF);
        check_rd(1'b0, DATP, 8'hFF, "R6");

        // R3: exit key locks, reads return all ones
        bus_write(IDXP, 8'hAA);
        check_open(1'b0, "R3");
        check_rd(1'b0, DATP, 8'hFF, "R4");

        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R9 missing strobes: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule